// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer for an 8-Bit Four-Register Core

This block is the control core of a small 8-bit processor. It reads 16-bit instruction words from a byte-wide synchronous memory port, one byte per read and the high byte first. It splits each word into an opcode, a destination index, a source index and an 8-bit immediate. It then carries the instruction out over several clock cycles. It holds the program counter, the stack pointer, four 8-bit general registers and a four-bit flag set.

Arithmetic is not done inside the block. An external combinational ALU receives the opcode and two register operands, and it returns a result and a flag nibble. The sequencer decides whether that result is written back and how the flags are kept. Memory-referencing and control-transfer instructions carry a second 16-bit word that holds an absolute address. The sequencer fetches this word the same way as the instruction word, and uses its low address bits as the target.

The block is meant to sit beside a single-port byte RAM that returns read data one cycle after a read strobe. Programs run from address 0 after reset until a stop instruction raises the halted output.

Top module: `seq_core`

## Requirements
- R1: While reset is high and just after it, `halted`, `mem_re` and `mem_we` are 0. PC, SP-independent state, registers and flags are cleared, so the first byte read after reset is at address 0.
- R2: A 16-bit word is read as two byte reads at consecutive addresses, high byte first. Bits [15:12] are the opcode, [11:10] the destination index rd, [9:8] the source index rs and [7:0] an immediate.
- R3: Opcodes 0x0 to 0x8 present the opcode on `alu_op`, R[rd] on `alu_a` and R[rs] on `alu_b`, write `alu_res` into R[rd] and advance PC by 2. `alu_flags` is bit 3 Z, bit 2 N, bit 1 C, bit 0 V.
- R4: Opcode 0x9 (compare) updates only the flags and leaves R[rd] unchanged.
- R5: Opcode 0xA loads the byte at the address word into R[rd]. Opcode 0xB writes R[rs] to that address. Both advance PC by 4, and a read and a write strobe are never raised together.
- R6: Opcode 0xC sets PC to the address word.
- R7: Opcode 0xD jumps when the condition in imm8[2:0] holds: 0 Z set, 1 Z clear, 2 C set, 3 C clear, 4 N set, 5 N clear, 6 V set, 7 V clear.
- R8: A conditional jump that is not taken advances PC by 4, past its address word.
- R9: Opcode 0xE pushes PC+4 as a 16-bit value and then jumps. SP resets to the last address 2^ADDR_W-1 and is decremented before each byte is written. The low byte is written first, so the high byte ends at the lower address.
- R10: For opcodes 0x2 to 0x6 (AND, OR, XOR, SHL, SHR), Z and N come from the ALU and C and V are stored as 0, whatever the ALU reports. For opcodes 0x0, 0x1, 0x7, 0x8 and 0x9, all four flags come from the ALU.
- R11: Opcode 0xF raises `halted`, which stays high. After that no further memory reads or writes are made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Byte address for the memory port |
| mem_re | output | 1 | Read strobe; data returns on mem_rdata one cycle later |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| alu_op | output | 4 | Opcode presented to the ALU |
| alu_a | output | 8 | Operand from R[rd] |
| alu_b | output | 8 | Operand from R[rs] |
| alu_res | input | 8 | ALU result |
| alu_flags | input | 4 | ALU flags {Z,N,C,V} |
| halted | output | 1 | High once the stop instruction has executed |

## Verification
One program runs through all of the opcode classes. Each conditional jump condition sits on a path where a wrong decision either writes an unexpected byte or stops early. This separates a taken jump from an untaken one and from a jump that moves PC by the wrong amount. The bench ALU deliberately reports C and V set for logic operations, so a sequencer that passes those flags through takes the wrong branch. Store data after compare, multiply and divide shows whether write-back happened. The two stack bytes are checked in write order, which tells the byte order and the pre-decrement apart.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'h0, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR, OP_MUL,
    OP_DIV, OP_CMP, OP_LOAD, OP_STORE, OP_JMP, OP_JCC, OP_CALL, OP_HALT
  } op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;

  // IA/IB issue the two byte reads, IC/ID collect them
  typedef enum logic [3:0] {
    S_IA, S_IB, S_IC, S_ID, S_DEC, S_EXE, S_LDB, S_LDC, S_PUSH_HI, S_HALT
  } st_e;
endpackage

// File: rtl/seq_regfile.sv
`timescale 1ns/1ps
module seq_regfile #(
  parameter int W = 8,
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ra_idx,
  input  logic [IW-1:0] rb_idx,
  output logic [W-1:0]  ra,
  output logic [W-1:0]  rb
);
  logic [W-1:0] q [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q[g] <= '0;
      else if (we && widx == IW'(g)) q[g] <= wdata;
    end
  end

  assign ra = q[ra_idx];
  assign rb = q[rb_idx];

  // R3: a write is visible in the selected register on the next cycle
  p_wr_lands_r3: assert property (@(posedge clk) disable iff (rst)
    we |=> q[$past(widx)] == $past(wdata));
endmodule

// File: rtl/seq_flagupd.sv
`timescale 1ns/1ps
module seq_flagupd
  import seq_pkg::*;
(
  input  logic [3:0] op,
  input  flags_t     alu_fl,
  output flags_t     nxt
);
  always_comb begin
    nxt = alu_fl;
    if (op >= 4'(OP_AND) && op <= 4'(OP_SHR)) begin
      nxt.c = 1'b0;
      nxt.v = 1'b0;
    end
  end
endmodule

// File: rtl/seq_cond.sv
`timescale 1ns/1ps
module seq_cond
  import seq_pkg::*;
(
  input  flags_t     fl,
  input  logic [2:0] sel,
  output logic       take
);
  logic pick;
  always_comb begin
    case (sel[2:1])
      2'd0:    pick = fl.z;
      2'd1:    pick = fl.c;
      2'd2:    pick = fl.n;
      default: pick = fl.v;
    endcase
  end
  // odd selector values test for the flag being clear
  assign take = pick ^ sel[0];
endmodule

// File: rtl/seq_core.sv
`timescale 1ns/1ps
module seq_core
  import seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NREG   = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [3:0]        alu_op,
  output logic [DATA_W-1:0] alu_a,
  output logic [DATA_W-1:0] alu_b,
  input  logic [DATA_W-1:0] alu_res,
  input  logic [3:0]        alu_flags,
  output logic              halted
);
  localparam int RIW = $clog2(NREG);
  localparam logic [ADDR_W-1:0] ONE   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP4 = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] SP_TOP = {ADDR_W{1'b1}};

  st_e st;
  logic [ADDR_W-1:0] pc, sp, tgt;
  logic              word_sel;
  logic [7:0]        hi_byte;
  op_e               op_q;
  logic [RIW-1:0]    rd_q, rs_q;
  logic [2:0]        cc_q;
  flags_t            fl, fl_nxt;

  logic [ADDR_W-1:0] pc_plus4;
  logic [15:0]       ret16;
  logic              take;
  logic              rf_we;
  logic [DATA_W-1:0] rf_wdata, ra, rb;

  assign pc_plus4 = pc + STEP4;
  assign ret16    = 16'(pc_plus4);

  assign rf_we    = (st == S_DEC && op_q < OP_CMP) || st == S_LDC;
  assign rf_wdata = (st == S_LDC) ? mem_rdata : alu_res;

  seq_regfile #(.W(DATA_W), .N(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .widx(rd_q), .wdata(rf_wdata),
    .ra_idx(rd_q), .rb_idx(rs_q), .ra(ra), .rb(rb)
  );

  seq_flagupd u_fu (.op(op_q), .alu_fl(flags_t'(alu_flags)), .nxt(fl_nxt));
  seq_cond    u_cc (.fl(fl), .sel(cc_q), .take(take));

  assign alu_op = op_q;
  assign alu_a  = ra;
  assign alu_b  = rb;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IA;
      pc <= '0;
      sp <= SP_TOP;
      tgt <= '0;
      word_sel <= 1'b0;
      hi_byte <= '0;
      op_q <= OP_ADD;
      rd_q <= '0;
      rs_q <= '0;
      cc_q <= '0;
      fl <= '0;
      halted <= 1'b0;
      mem_addr <= '0;
      mem_re <= 1'b0;
      mem_we <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_re <= 1'b0;
      mem_we <= 1'b0;
      case (st)
        S_IA: begin
          mem_re   <= 1'b1;
          mem_addr <= word_sel ? pc + STEP2 : pc;
          st       <= S_IB;
        end
        S_IB: begin
          mem_re   <= 1'b1;
          mem_addr <= mem_addr + ONE;
          st       <= S_IC;
        end
        S_IC: begin
          hi_byte <= mem_rdata;
          st      <= S_ID;
        end
        S_ID: begin
          if (!word_sel) begin
            op_q <= op_e'(hi_byte[7:4]);
            rd_q <= RIW'(hi_byte[3:2]);
            rs_q <= RIW'(hi_byte[1:0]);
            cc_q <= mem_rdata[2:0];
            st   <= S_DEC;
          end else begin
            tgt <= ADDR_W'({hi_byte, mem_rdata});
            st  <= S_EXE;
          end
        end
        S_DEC: begin
          if (op_q <= OP_CMP) begin
            fl <= fl_nxt;
            pc <= pc + STEP2;
            st <= S_IA;
          end else if (op_q == OP_HALT) begin
            halted <= 1'b1;
            st     <= S_HALT;
          end else begin
            word_sel <= 1'b1;
            st       <= S_IA;
          end
        end
        S_EXE: begin
          word_sel <= 1'b0;
          st       <= S_IA;
          case (op_q)
            OP_LOAD: begin
              mem_re   <= 1'b1;
              mem_addr <= tgt;
              st       <= S_LDB;
            end
            OP_STORE: begin
              mem_we    <= 1'b1;
              mem_addr  <= tgt;
              mem_wdata <= rb;
              pc        <= pc_plus4;
            end
            OP_JMP: pc <= tgt;
            OP_JCC: pc <= take ? tgt : pc_plus4;
            OP_CALL: begin
              mem_we    <= 1'b1;
              mem_addr  <= sp - ONE;
              mem_wdata <= ret16[7:0];
              sp        <= sp - ONE;
              st        <= S_PUSH_HI;
            end
            default: pc <= pc_plus4;
          endcase
        end
        S_LDB: st <= S_LDC;
        S_LDC: begin
          pc <= pc_plus4;
          st <= S_IA;
        end
        S_PUSH_HI: begin
          mem_we    <= 1'b1;
          mem_addr  <= sp - ONE;
          mem_wdata <= ret16[15:8];
          sp        <= sp - ONE;
          pc        <= tgt;
          st        <= S_IA;
        end
        default: st <= S_HALT;
      endcase
    end
  end

  // R5: the port never reads and writes in the same cycle
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));
  // R11: halted is sticky
  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  // R11: no memory traffic once halted
  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_re && !mem_we);
  // R9: the second push steps SP down by one more
  p_sp_step_r9: assert property (@(posedge clk) disable iff (rst)
    st == S_PUSH_HI |=> sp == $past(sp) - ONE);
  // R2: the second byte of a word comes from the next address
  p_fetch_seq_r2: assert property (@(posedge clk) disable iff (rst)
    st == S_IB |=> mem_re && mem_addr == $past(mem_addr) + ONE);
endmodule

// File: tb/seq_core_bench.sv
`timescale 1ns/1ps
module seq_core_bench;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic mem_re, mem_we, halted;
  logic [7:0] mem_wdata, mem_rdata, alu_a, alu_b, alu_res;
  logic [3:0] alu_op, alu_flags;

  logic [7:0] mem   [256];
  logic [7:0] image [256];

  int n_chk = 0, n_err = 0, nrd = 0, rd_after_halt = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] e;
  string       t;

  always #2 clk = ~clk;

  seq_core u_seq_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .alu_op(alu_op), .alu_a(alu_a),
    .alu_b(alu_b), .alu_res(alu_res), .alu_flags(alu_flags), .halted(halted)
  );

  // synchronous memory, reloaded from the image during reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= image[i];
      mem_rdata <= '0;
    end else begin
      if (mem_re) mem_rdata <= mem[mem_addr];
      if (mem_we) mem[mem_addr] <= mem_wdata;
    end
  end

  // reference ALU; logic ops report C and V set on purpose (R10)
  always_comb begin
    logic [8:0]  s;
    logic [15:0] p;
    logic        c, v;
    c = 1'b0; v = 1'b0; s = '0; p = '0;
    case (alu_op)
      4'h0: begin s = {1'b0, alu_a} + {1'b0, alu_b}; alu_res = s[7:0]; c = s[8];
              v = (alu_a[7] == alu_b[7]) && (s[7] != alu_a[7]); end
      4'h1, 4'h9: begin alu_res = alu_a - alu_b; c = alu_a < alu_b;
              v = (alu_a[7] != alu_b[7]) && (alu_res[7] != alu_a[7]); end
      4'h2: begin alu_res = alu_a & alu_b; c = 1'b1; v = 1'b1; end
      4'h3: begin alu_res = alu_a | alu_b; c = 1'b1; v = 1'b1; end
      4'h4: begin alu_res = alu_a ^ alu_b; c = 1'b1; v = 1'b1; end
      4'h5: begin alu_res = {alu_a[6:0], 1'b0}; c = 1'b1; v = 1'b1; end
      4'h6: begin alu_res = {1'b0, alu_a[7:1]}; c = 1'b1; v = 1'b1; end
      4'h7: begin p = alu_a * alu_b; alu_res = p[7:0]; c = p[15:8] != 0; end
      4'h8: alu_res = (alu_b == 0) ? 8'hFF : alu_a / alu_b;
      default: alu_res = '0;
    endcase
    alu_flags = {alu_res == 8'h00, alu_res[7], c, v};
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [1:0] rd,
                                      input logic [1:0] rs, input logic [7:0] imm);
    return {op, rd, rs, imm};
  endfunction

  task automatic put(input int a, input logic [15:0] w);
    image[a]   = w[15:8];
    image[a+1] = w[7:0];
  endtask

  task automatic expect_wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    exp_q.push_back({a, d});
    tag_q.push_back(tag);
  endtask

  // monitor: pops expected writes in order, watches reads
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_re) begin
        nrd++;
        if (nrd == 1) check(mem_addr == 8'h00, "R1", "first read address", 16'(mem_addr), 16'h0000);
        if (nrd == 2) check(mem_addr == 8'h01, "R2", "second byte address", 16'(mem_addr), 16'h0001);
        if (halted) rd_after_halt++;
      end
      if (mem_we) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11", "write after program end", {mem_addr, mem_wdata}, 16'h0000);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({mem_addr, mem_wdata} == e, t, "memory write {addr,data}", {mem_addr, mem_wdata}, e);
        end
      end
    end
  end

  initial begin
    int cyc;
    for (int i = 0; i < 256; i++) image[i] = 8'hF0;  // all HALT
    image[8'hC0] = 8'h05; image[8'hC1] = 8'h03;
    image[8'hC2] = 8'hFF; image[8'hC3] = 8'h80;
    put(8'h00, enc(4'hA, 0, 0, 0)); put(8'h02, 16'h00C0);   // R0 = 5
    put(8'h04, enc(4'hA, 1, 0, 0)); put(8'h06, 16'h00C1);   // R1 = 3
    put(8'h08, enc(4'h0, 0, 1, 0));                         // R0 = 8
    put(8'h0A, enc(4'hB, 0, 0, 0)); put(8'h0C, 16'h00D0);
    put(8'h0E, enc(4'h1, 1, 0, 0));                         // R1 = FB, C=1 N=1
    put(8'h10, enc(4'hD, 0, 0, 2)); put(8'h12, 16'h0020);   // JC taken
    put(8'h20, enc(4'hB, 0, 1, 0)); put(8'h22, 16'h00D1);
    put(8'h24, enc(4'h9, 0, 0, 0));                         // CMP R0,R0 Z=1
    put(8'h26, enc(4'hD, 0, 0, 1)); put(8'h28, 16'h0040);   // JNZ untaken
    put(8'h2A, enc(4'hB, 0, 0, 0)); put(8'h2C, 16'h00D2);
    put(8'h2E, enc(4'hA, 2, 0, 0)); put(8'h30, 16'h00C2);   // R2 = FF
    put(8'h32, enc(4'hA, 3, 0, 0)); put(8'h34, 16'h00C3);   // R3 = 80
    put(8'h36, enc(4'h0, 3, 3, 0));                         // R3 = 0, C=1 V=1
    put(8'h38, enc(4'hD, 0, 0, 6)); put(8'h3A, 16'h0044);   // JV taken
    put(8'h44, enc(4'h2, 2, 2, 0));                         // AND: N=1, C/V cleared
    put(8'h46, enc(4'hD, 0, 0, 3)); put(8'h48, 16'h0050);   // JNC taken
    put(8'h4A, enc(4'hB, 0, 2, 0)); put(8'h4C, 16'h00DF);   // wrong path
    put(8'h50, enc(4'hD, 0, 0, 4)); put(8'h52, 16'h0058);   // JN taken
    put(8'h58, enc(4'hE, 0, 0, 0)); put(8'h5A, 16'h0070);   // CALL
    put(8'h70, enc(4'hB, 0, 3, 0)); put(8'h72, 16'h00D3);
    put(8'h74, enc(4'h6, 2, 0, 0));                         // SHR R2 = 7F
    put(8'h76, enc(4'hD, 0, 0, 5)); put(8'h78, 16'h007C);   // JP taken
    put(8'h7C, enc(4'h7, 2, 1, 0));                         // MUL = 85
    put(8'h7E, enc(4'hB, 0, 2, 0)); put(8'h80, 16'h00D4);
    put(8'h82, enc(4'hC, 0, 0, 0)); put(8'h84, 16'h0090);   // JMP
    put(8'h90, enc(4'hD, 0, 0, 0)); put(8'h92, 16'h0086);   // JZ untaken
    put(8'h94, enc(4'hD, 0, 0, 7)); put(8'h96, 16'h009C);   // JNV taken
    put(8'h9C, enc(4'h8, 0, 1, 0));                         // DIV 8/FB = 0
    put(8'h9E, enc(4'hD, 0, 0, 0)); put(8'h9A, 16'hF0F0);
    put(8'hA0, 16'h00A8);                                   // JZ taken
    put(8'hA8, enc(4'hB, 0, 0, 0)); put(8'hAA, 16'h00D5);

    expect_wr(8'hD0, 8'h08, "R3 R5 load/add/store");
    expect_wr(8'hD1, 8'hFB, "R7 R3 sub then C-set jump");
    expect_wr(8'hD2, 8'h08, "R4 R8 compare keeps rd, untaken jump +4");
    expect_wr(8'hFE, 8'h5C, "R9 R10 push low byte after C-clear jump");
    expect_wr(8'hFD, 8'h00, "R9 push high byte");
    expect_wr(8'hD3, 8'h00, "R7 R3 V-set jump, add wrap");
    expect_wr(8'hD4, 8'h85, "R3 R7 shift, N-clear jump, multiply");
    expect_wr(8'hD5, 8'h00, "R6 R7 R8 jump, Z/V tests, divide");

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(halted == 1'b0, "R1", "halted in reset", 16'(halted), 16'h0);
    check(mem_re == 1'b0, "R1", "read strobe in reset", 16'(mem_re), 16'h0);
    check(mem_we == 1'b0, "R1", "write strobe in reset", 16'(mem_we), 16'h0);
    rst = 1'b0;

    cyc = 0;
    while (!halted && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    if (!halted) check(1'b0, "R11", "watchdog expired", 16'(cyc), 16'h0);

    repeat (20) @(negedge clk);
    check(halted == 1'b1, "R11", "halted stays high", 16'(halted), 16'h1);
    check(rd_after_halt == 0, "R11", "reads after halt", 16'(rd_after_halt), 16'h0);
    check(mem_we == 1'b0, "R11", "write strobe after halt", 16'(mem_we), 16'h0);
    check(exp_q.size() == 0, (tag_q.size() != 0) ? tag_q[0] : "R11",
          "expected writes left", 16'(exp_q.size()), 16'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule